// File: doc/BRIEF.md
# Paced Digital Input Capture Front-End

This block takes parallel words from an input bus and writes them into a small FIFO. The rate of these writes depends on a sample source that is chosen at run time. Two fixed rates come from a free-running prescaler on the system clock. The first divides by 2, which gives 20 MHz from a 40 MHz system clock. The second divides by 4, which gives 10 MHz. A third source is a 16-bit reloading pacer that sets a programmable rate. The last source is an external request strobe: each rising edge of the strobe causes one word to be taken. The consumer drains the FIFO through a show-ahead read port.

In strobe mode, the outside device is paced by the acknowledge output. This output is high while the FIFO holds fewer words than a programmable almost-full level. Because that level is set below the FIFO depth, words already in transit after the acknowledge drops still fit in the FIFO. If a write arrives when the FIFO is full, the word is discarded and a sticky overrun flag is set.

Software picks the source with `mode_sel`. The block only takes in this choice while capture is disabled. As a result, the source in use never changes in the middle of a capture run.

Top module: `paced_capture`

## Requirements
- R1: While reset is asserted, and after it is released, the FIFO is empty (`empty`=1, `level`=0), `overrun` is 0, and the pacer count is cleared. A reset asserted in the middle of a run clears all three.
- R2: Source code 2'b00 (fast): while `cap_en` is high, the prescaler counts from 0. `din` is written on every second enabled cycle, starting with the second cycle.
- R3: Source code 2'b01 (half): while `cap_en` is high, `din` is written on every fourth enabled cycle, starting with the fourth cycle.
- R4: Source code 2'b10 (pacer): the pacer writes `din` once every max(`pace_div`,2) cycles. A `pace_div` of 0 or 1 therefore acts as 2. The pacer reloads while capture is disabled.
- R5: Source code 2'b11 (strobe): `req_in` goes through two synchronizer flops. Exactly one word is written per rising edge of the synchronized request, whatever the width of the high pulse. The word is taken at the third clock edge after `req_in` is seen high.
- R6: `ack_out` is 1 exactly when `level` is below `afull_lvl`.
- R7: A write that arrives while `level` equals the depth is discarded. It sets `overrun`, which stays at 1 until reset.
- R8: `mode_sel` is registered only on cycles where `cap_en` is low. A change made while capture is enabled has no effect on the capture rate.
- R9: A high `rd_en` with a non-empty FIFO removes the oldest word. `rd_data` always shows the oldest word held. A high `rd_en` on an empty FIFO changes nothing.
- R10: While `cap_en` is low, no source writes a word, including request edges in strobe mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture enable |
| mode_sel | input | 2 | Sample source select |
| pace_div | input | CW | Pacer divisor |
| afull_lvl | input | LW | Almost-full level |
| din | input | DW | Parallel input word |
| req_in | input | 1 | External sample request strobe |
| ack_out | output | 1 | Ready to accept further requests |
| rd_en | input | 1 | FIFO pop |
| rd_data | output | DW | Oldest stored word |
| empty | output | 1 | FIFO holds no word |
| level | output | LW | Words held |
| overrun | output | 1 | Sticky dropped-write flag |

## Verification
The bench builds the block with a depth of 8, a data width of 8 and a 16-bit pacer. With this small depth, about a dozen strobes are enough to cross the almost-full level of 6 and reach the full and overrun cases. The pacer is run with divisors 0, 1 and 5, which covers both the clamped case and a long period within short runs. Request pulses of widths 1, 3 and 8 cycles show that a long pulse still yields a single word.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
  typedef enum logic [1:0] {
    SRC_FAST   = 2'b00,
    SRC_HALF   = 2'b01,
    SRC_PACER  = 2'b10,
    SRC_STROBE = 2'b11
  } src_mode_t;
endpackage

// File: rtl/pcap_rate_gen.sv
module pcap_rate_gen #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          pacer_sel,
  input  logic [CW-1:0] div,
  output logic          tick_fast,
  output logic          tick_half,
  output logic          tick_pacer
);
  localparam logic [CW-1:0] MIN_DIV = CW'(2);

  logic [1:0]    pre_q, pre_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] reload;

  always_comb begin
    reload = ((div < MIN_DIV) ? MIN_DIV : div) - CW'(1);
    pre_d  = run ? pre_q + 2'd1 : 2'd0;
    if (!run || cnt_q == '0) cnt_d = reload;
    else                     cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign tick_fast  = run && pre_q[0];
  assign tick_half  = run && (pre_q == 2'd3);
  assign tick_pacer = run && (cnt_q == '0);

  assert_idle_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(tick_fast || tick_half || tick_pacer));
  assert_pacer_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_pacer && pacer_sel) |=> !tick_pacer);
endmodule

// File: rtl/pcap_req_sync.sv
module pcap_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  output logic rise_o
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], req_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[STAGES-1] && !sh_q[STAGES];

  assert_one_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pcap_fifo.sv
module pcap_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [DW-1:0]              wr_data,
  input  logic                       rd_en,
  output logic [DW-1:0]              rd_data,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       overrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          ovr_q, ovr_d;
  logic          full, do_wr, do_rd;

  always_comb begin
    full  = (cnt_q == LW'(DEPTH));
    do_wr = wr_en && !full;
    do_rd = rd_en && (cnt_q != '0);
    wp_d  = do_wr ? ((wp_q == LAST) ? '0 : wp_q + AW'(1)) : wp_q;
    rp_d  = do_rd ? ((rp_q == LAST) ? '0 : rp_q + AW'(1)) : rp_q;
    cnt_d = cnt_q + LW'(do_wr) - LW'(do_rd);
    ovr_d = ovr_q || (wr_en && full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wr_data;
  end

  assign rd_data = mem[rp_q];
  assign level   = cnt_q;
  assign overrun = ovr_q;

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LW'(DEPTH));
  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);
  assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en) |=> (cnt_q == LW'(DEPTH)));
endmodule

// File: rtl/paced_capture.sv
module paced_capture #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int CW    = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [1:0]    mode_sel,
  input  logic [CW-1:0] pace_div,
  input  logic [LW-1:0] afull_lvl,
  input  logic [DW-1:0] din,
  input  logic          req_in,
  output logic          ack_out,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic [LW-1:0] level,
  output logic          overrun
);
  import pcap_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  src_mode_t  mode_q, mode_d;
  logic       t_fast, t_half, t_pacer, req_rise;
  logic       sample;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb mode_d = cap_en ? mode_q : src_mode_t'(mode_sel);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) mode_q <= SRC_FAST;
    else            mode_q <= mode_d;
  end

  pcap_rate_gen #(.CW(CW)) u_rate (
    .clk(clk), .rst_n(rst_int_n), .run(cap_en),
    .pacer_sel(mode_q == SRC_PACER), .div(pace_div),
    .tick_fast(t_fast), .tick_half(t_half), .tick_pacer(t_pacer)
  );

  pcap_req_sync #(.STAGES(2)) u_req (
    .clk(clk), .rst_n(rst_int_n), .req_in(req_in), .rise_o(req_rise)
  );

  always_comb begin
    unique case (mode_q)
      SRC_FAST:   sample = t_fast;
      SRC_HALF:   sample = t_half;
      SRC_PACER:  sample = t_pacer;
      SRC_STROBE: sample = cap_en && req_rise;
      default:    sample = 1'b0;
    endcase
  end

  pcap_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_int_n), .wr_en(sample), .wr_data(din),
    .rd_en(rd_en), .rd_data(rd_data), .level(level), .overrun(overrun)
  );

  assign empty   = (level == '0);
  assign ack_out = (level < afull_lvl);

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cap_en && $past(cap_en)) |-> $stable(mode_q));
  assert_no_write_idle_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!cap_en && !rd_en) |=> $stable(level));
  assert_ack_full_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (level >= afull_lvl) |-> !ack_out);
endmodule

// File: tb/paced_capture_test.sv
`timescale 1ns/1ps
module paced_capture_test;
  localparam int DW = 8, DEPTH = 8, CW = 16, LW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cap_en;
  logic [1:0]    mode_sel;
  logic [CW-1:0] pace_div;
  logic [LW-1:0] afull_lvl;
  logic [DW-1:0] din;
  logic          req_in, rd_en;
  logic          ack_out, empty, overrun;
  logic [DW-1:0] rd_data;
  logic [LW-1:0] level;

  int total = 0, bad = 0, cycles = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  paced_capture #(.DW(DW), .DEPTH(DEPTH), .CW(CW), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .mode_sel(mode_sel),
    .pace_div(pace_div), .afull_lvl(afull_lvl), .din(din), .req_in(req_in),
    .ack_out(ack_out), .rd_en(rd_en), .rd_data(rd_data), .empty(empty),
    .level(level), .overrun(overrun));

  // behavioural reference
  logic [DW-1:0] q[$];
  int  m_mode, m_pre, m_pc;
  bit  m_ovr, s1, s2, s3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_ovr = 0; m_mode = 0; m_pre = 0; m_pc = 0;
      s1 = 0; s2 = 0; s3 = 0;
    end else begin
      int  eff;
      bit  wr, rd, full, rise;
      eff  = (pace_div < 2) ? 2 : int'(pace_div);
      rise = s2 && !s3;
      case (m_mode)
        0: wr = cap_en && (m_pre % 2 == 1);
        1: wr = cap_en && (m_pre == 3);
        2: wr = cap_en && (m_pc == 0);
        default: wr = cap_en && rise;
      endcase
      full = (q.size() == DEPTH);
      rd   = rd_en && (q.size() > 0);
      if (rd) void'(q.pop_front());
      if (wr) begin
        if (!full) q.push_back(din);
        else m_ovr = 1;
      end
      m_pre = cap_en ? (m_pre + 1) % 4 : 0;
      if (!cap_en || m_pc == 0) m_pc = eff - 1; else m_pc = m_pc - 1;
      if (!cap_en) m_mode = int'(mode_sel);
      s3 = s2; s2 = s1; s1 = req_in;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    chk(tag, "level", int'(level), q.size());
    chk("R6", "ack_out", int'(ack_out), int'(q.size() < int'(afull_lvl)));
    chk("R7", "overrun", int'(overrun), int'(m_ovr));
    chk("R9", "empty", int'(empty), int'(q.size() == 0));
    if (q.size() > 0) chk("R9", "rd_data", int'(rd_data), int'(q[0]));
    if (cycles > 20000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc(int n);
    repeat (n) begin
      @(negedge clk);
      din = din + 8'h13;
    end
  endtask

  task automatic drain();
    cap_en = 0; rd_en = 1; cyc(DEPTH + 2); rd_en = 0; cyc(1);
  endtask

  task automatic pulse(int hi, int lo);
    req_in = 1; cyc(hi); req_in = 0; cyc(lo);
  endtask

  initial begin
    rst_n = 0; cap_en = 0; mode_sel = 0; pace_div = 0; afull_lvl = 4'd6;
    din = 8'h05; req_in = 0; rd_en = 0;
    cyc(3);
    rst_n = 1; cyc(4);

    tag = "R2"; mode_sel = 2'b00; cyc(2); cap_en = 1; cyc(9);
    tag = "R8"; mode_sel = 2'b11; cyc(4);
    tag = "R9"; drain();

    tag = "R3"; mode_sel = 2'b01; cyc(2); cap_en = 1; cyc(14); drain();

    tag = "R4"; mode_sel = 2'b10; pace_div = 0; cyc(2); cap_en = 1; cyc(8); drain();
    pace_div = 1; cap_en = 1; cyc(6); drain();
    pace_div = 5; cap_en = 1; cyc(22); drain();

    tag = "R5"; mode_sel = 2'b11; cyc(2); cap_en = 1;
    pulse(1, 3); pulse(3, 4); pulse(8, 2); pulse(2, 2);
    tag = "R7";
    for (int i = 0; i < 7; i++) pulse(1 + i % 3, 3);
    cap_en = 0; cyc(3);

    tag = "R10"; pulse(2, 3); pulse(1, 4);
    tag = "R9"; drain();

    tag = "R1"; cap_en = 1; pulse(2, 3); pulse(2, 3); cap_en = 0; cyc(1);
    @(posedge clk); #1 rst_n = 0;
    cyc(2); rst_n = 1; cyc(4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule